// File: doc/BRIEF.md
# Nested Priority Event Controller

This block arbitrates the event requests of a processor core across sixteen fixed priority levels and records which service routines are running. Level 0 ranks highest. The levels are assigned as follows: emulation 0, reset 1, non-maskable interrupt 2, exception 3, an unused slot 4, hardware error 5, core timer 6, and general-purpose levels 7 to 15. A request stays latched as pending until its level is taken. When a pending, enabled level has a strictly higher priority than every routine already in service, the block raises a take pulse in the same cycle and reports the level. On the next edge, that level moves from pending to active.

Software can enable or disable levels 5 to 15 through a mask register. It can also raise the two lowest levels directly. A return strobe ends the routine with the highest priority. The active bitmap is the nesting stack, so returns unwind in priority order.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After reset, no level is pending or active and `take_o` is low. The mask register is all zero, so a level 5 to 15 request does not produce a take until its mask bit is written to 1.
- R2: Among pending, enabled levels, the level with the smallest number wins.
- R3: When `take_o` is high, `take_lvl_o` gives the winner. After the next edge, that level's bit in `active_o` is set and its pending bit is cleared.
- R4: A take happens only if the winner's number is smaller than that of every active level. Requests at equal or lower priority stay pending and are taken later.
- R5: `exc_req_i` gives level 3 a take pulse in the same cycle it is asserted, provided nothing at levels 0 to 3 is active or pending ahead of it.
- R6: Level 2 is requested by `nmi_pin_i` OR `wdog_nmi_i`.
- R7: `rfe_i` clears the lowest-numbered set bit of `active_o` at the next edge. No take is issued in a cycle with `rfe_i` high.
- R8: Levels 0 to 3 ignore the mask. Levels 5 to 15 take part only when their mask bit is 1, where bit n corresponds to level n. A masked request remains pending. A mask write takes effect from the next cycle.
- R9: When `swi_wr_i` is high, `swi_wdata_i[0]` raises level 14 and `swi_wdata_i[1]` raises level 15 as pending from the next cycle.
- R10: Level 4 is never taken. Bits 2, 3 and 4 of `evt_req_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| evt_req_i | input | 16 | Request line per level (bits 2,3,4 unused) |
| nmi_pin_i | input | 1 | External non-maskable request |
| wdog_nmi_i | input | 1 | Watchdog timeout non-maskable request |
| exc_req_i | input | 1 | Synchronous exception request |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 16 | Mask value, 1 enables a level |
| swi_wr_i | input | 1 | Software raise write strobe |
| swi_wdata_i | input | 2 | Write-one raise bits for levels 14 and 15 |
| rfe_i | input | 1 | Return-from-event strobe |
| take_o | output | 1 | An event is taken this cycle |
| take_lvl_o | output | 4 | Level being taken |
| active_o | output | 16 | Bitmap of levels in service |

## Verification
The assertions assume that `rfe_i` is pulsed only while a routine is active. The exception is the unwinding loop, where an extra strobe on an empty bitmap has no effect. They also assume that inputs are stable around the clock edge. The stimulus changes every input only on the falling edge and holds each request for a single cycle, which relies on the pending latch to keep it. Return strobes always alternate with idle cycles, so every pending level gets a chance to be taken between two unwinds.

// File: rtl/nest_evt_pkg.sv
package nest_evt_pkg;
    localparam int NUM_LVL = 16;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int LVL_NMI = 2;
    localparam int LVL_EXC = 3;
    localparam int LVL_RSV = 4;
    localparam int FIRST_MASKABLE = 5;
    localparam int SWI_LO  = NUM_LVL - 2;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    typedef struct packed {
        lvl_vec_t pend;
        lvl_vec_t act;
        lvl_vec_t mask;
    } ctrl_state_t;
endpackage

// File: rtl/nest_evt_prio.sv
module nest_evt_prio #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = W'(i);
            end
        end
    end
endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl
    import nest_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      evt_req_i,
    input  logic             nmi_pin_i,
    input  logic             wdog_nmi_i,
    input  logic             exc_req_i,
    input  logic             mask_wr_i,
    input  logic [15:0]      mask_wdata_i,
    input  logic             swi_wr_i,
    input  logic [1:0]       swi_wdata_i,
    input  logic             rfe_i,
    output logic             take_o,
    output logic [3:0]       take_lvl_o,
    output logic [15:0]      active_o
);
    localparam lvl_vec_t FIXED_EN  = lvl_vec_t'((1 << LVL_RSV) - 1);
    localparam lvl_vec_t MASKABLE  = ~lvl_vec_t'((1 << FIRST_MASKABLE) - 1);
    localparam lvl_vec_t DEDICATED = lvl_vec_t'((1 << LVL_NMI) | (1 << LVL_EXC) | (1 << LVL_RSV));

    ctrl_state_t state_d, state_q;

    lvl_vec_t           raw_req;
    lvl_vec_t           pend_now;
    lvl_vec_t           eligible;
    logic               win_any, act_any;
    logic [LVL_W-1:0]   win_idx, act_idx;
    logic               take;

    always_comb begin
        raw_req = evt_req_i & ~DEDICATED;
        raw_req[LVL_NMI] = nmi_pin_i | wdog_nmi_i;
        raw_req[LVL_EXC] = exc_req_i;
        pend_now = state_q.pend | raw_req;
        eligible = pend_now & (FIXED_EN | (state_q.mask & MASKABLE));
    end

    nest_evt_prio #(.N(NUM_LVL)) win_enc_i (
        .vec_i (eligible),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    nest_evt_prio #(.N(NUM_LVL)) act_enc_i (
        .vec_i (state_q.act),
        .any_o (act_any),
        .idx_o (act_idx)
    );

    always_comb begin
        state_d = state_q;
        take = win_any && !rfe_i && (!act_any || (win_idx < act_idx));

        state_d.pend = pend_now;
        if (take) begin
            state_d.pend[win_idx] = 1'b0;
            state_d.act[win_idx]  = 1'b1;
        end
        if (rfe_i && act_any) begin
            state_d.act[act_idx] = 1'b0;
        end
        if (swi_wr_i) begin
            state_d.pend[SWI_LO]     = state_d.pend[SWI_LO]     | swi_wdata_i[0];
            state_d.pend[SWI_LO + 1] = state_d.pend[SWI_LO + 1] | swi_wdata_i[1];
        end
        if (mask_wr_i) begin
            state_d.mask = mask_wdata_i & MASKABLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign take_o     = take;
    assign take_lvl_o = win_idx;
    assign active_o   = state_q.act;
endmodule

// File: rtl/nest_evt_chk.sv
module nest_evt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rfe_i,
    input logic        take_o,
    input logic [3:0]  take_lvl_o,
    input logic [15:0] active_o
);
    logic [15:0] upto_lvl;

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            upto_lvl[i] = (4'(i) <= take_lvl_o);
        end
    end

    AST_TAKE_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> active_o[$past(take_lvl_o)]); // R3

    AST_TAKE_GROWS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> ($countones(active_o) == $countones($past(active_o)) + 1)); // R3

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((active_o & upto_lvl) == 16'h0)); // R4

    AST_RFE_UNWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_i && (active_o != 16'h0)) |=> ($countones(active_o) + 1 == $countones($past(active_o)))); // R7

    AST_RFE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rfe_i |-> !take_o); // R7

    AST_RSV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o[4] && !(take_o && take_lvl_o == 4'd4)); // R10
endmodule

bind nest_evt_ctrl nest_evt_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rfe_i      (rfe_i),
    .take_o     (take_o),
    .take_lvl_o (take_lvl_o),
    .active_o   (active_o)
);

// File: tb/nest_evt_ctrl_tb_top.sv
module nest_evt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_req_i = '0;
    logic        nmi_pin_i = 1'b0, wdog_nmi_i = 1'b0, exc_req_i = 1'b0;
    logic        mask_wr_i = 1'b0, swi_wr_i = 1'b0, rfe_i = 1'b0;
    logic [15:0] mask_wdata_i = '0;
    logic [1:0]  swi_wdata_i = '0;
    logic        take_o;
    logic [3:0]  take_lvl_o;
    logic [15:0] active_o;

    int n_tests = 0;
    int n_fail  = 0;

    // staged stimulus for the next cycle
    logic [15:0] s_req = '0, s_mdata = '0;
    logic        s_pin = 0, s_wd = 0, s_exc = 0, s_mwr = 0, s_swr = 0, s_rfe = 0;
    logic [1:0]  s_sdata = '0;

    // behavioural reference state
    bit m_pend[16];
    bit m_act[16];
    bit m_en[16];

    always #10 clk = ~clk;

    nest_evt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req_i),
        .nmi_pin_i(nmi_pin_i), .wdog_nmi_i(wdog_nmi_i), .exc_req_i(exc_req_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .swi_wr_i(swi_wr_i), .swi_wdata_i(swi_wdata_i), .rfe_i(rfe_i),
        .take_o(take_o), .take_lvl_o(take_lvl_o), .active_o(active_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int actual, input int expected);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, actual, expected);
        end
    endtask

    task automatic tick(input string tag);
        bit nowp[16];
        bit exp_take;
        int win;
        int top;
        logic [15:0] exp_act;
        @(negedge clk);
        evt_req_i = s_req; nmi_pin_i = s_pin; wdog_nmi_i = s_wd; exc_req_i = s_exc;
        mask_wr_i = s_mwr; mask_wdata_i = s_mdata; swi_wr_i = s_swr;
        swi_wdata_i = s_sdata; rfe_i = s_rfe;
        #5;
        win = -1; top = 99;
        for (int i = 0; i < 16; i++) begin
            nowp[i] = m_pend[i];
            if (i == 2) nowp[i] = nowp[i] || s_pin || s_wd;
            else if (i == 3) nowp[i] = nowp[i] || s_exc;
            else if (i != 4) nowp[i] = nowp[i] || s_req[i];
        end
        for (int i = 15; i >= 0; i--) begin
            if (nowp[i] && (i < 4 || (i > 4 && m_en[i]))) win = i;
            if (m_act[i]) top = i;
        end
        exp_take = (win >= 0) && (win < top) && !s_rfe;
        for (int i = 0; i < 16; i++) exp_act[i] = m_act[i];
        check(take_o == exp_take, tag, "take", int'(take_o), int'(exp_take));
        if (exp_take)
            check(take_lvl_o == 4'(win), tag, "level", int'(take_lvl_o), win);
        check(active_o == exp_act, tag, "active", int'(active_o), int'(exp_act));
        // advance model
        for (int i = 0; i < 16; i++) m_pend[i] = nowp[i];
        if (exp_take) begin m_pend[win] = 0; m_act[win] = 1; end
        if (s_rfe && top < 16) m_act[top] = 0;
        if (s_swr) begin
            if (s_sdata[0]) m_pend[14] = 1;
            if (s_sdata[1]) m_pend[15] = 1;
        end
        if (s_mwr) for (int i = 0; i < 16; i++) m_en[i] = (i >= 5) && s_mdata[i];
        s_req = '0; s_pin = 0; s_wd = 0; s_exc = 0; s_mwr = 0; s_mdata = '0;
        s_swr = 0; s_sdata = '0; s_rfe = 0;
    endtask

    task automatic unwind(input string tag);
        for (int k = 0; k < 24; k++) begin
            s_rfe = (k % 2 == 0);
            tick(tag);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_pend[i] = 0; m_act[i] = 0; m_en[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        tick("R1");
        // level 7 while still masked after reset: held pending
        s_req = 16'h0080; tick("R1");
        tick("R8");
        s_mwr = 1; s_mdata = 16'hFFFF; tick("R8");
        tick("R3");  // level 7 taken now
        tick("R3");
        // equal and lower priority wait, higher preempts
        s_req = 16'h1080; tick("R4");
        s_req = 16'h0040; tick("R4");
        tick("R4");
        s_exc = 1; tick("R5");
        s_wd = 1; tick("R6");
        s_rfe = 1; tick("R7");
        s_pin = 1; tick("R6");
        unwind("R7");
        // unused request bits
        s_req = 16'h001C; tick("R10");
        tick("R10");
        tick("R10");
        // top levels ignore mask
        s_mwr = 1; s_mdata = 16'h0000; tick("R8");
        s_req = 16'h0002; tick("R8");
        s_req = 16'h0800; tick("R8");
        unwind("R7");
        // software raise
        s_mwr = 1; s_mdata = 16'hC000; tick("R9");
        s_swr = 1; s_sdata = 2'b11; tick("R9");
        tick("R9");
        unwind("R9");
        // simultaneous requests resolve by priority
        s_mwr = 1; s_mdata = 16'hFFFF; tick("R2");
        s_req = 16'h2121; tick("R2");
        tick("R2");
        s_req = 16'h0600; tick("R2");
        unwind("R2");
        s_req = 16'h8000; s_swr = 1; s_sdata = 2'b01; tick("R2");
        unwind("R2");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule